// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for a parameterised pin count that is a multiple of 32. Software reaches it through a plain 32-bit read/write port. Each function of the controller occupies its own bank of consecutive 32-bit words, one word per group of 32 pins. The alternate-function bank is the exception: it is twice as long, because it packs a 2-bit selector for each pin.

Pad inputs cross into the clock domain through a two-flop synchroniser. The synchronised value feeds the level bank and the edge detector. The controller drives an output-enable and an output value for every pad, exports the per-pin alternate-function selector, and raises one combined interrupt whenever any edge-status bit is pending.

Outputs are set and cleared with write-one masks, so one pin can be changed without a read-modify-write. Pending edges are acknowledged the same way.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With W = NUM_PINS/32, the bank indices are: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function. The word for pin p in bank b (b < 7) is at byte address (b·W + p/32)·4, and the pin sits at bit p mod 32.
- R2: A read of the level bank returns the pad input after two synchronising flops, whatever the pin's direction. Writes to the level bank change nothing.
- R3: A direction bit of 1 drives that pin's `pad_oe` high; a 0 makes the pin an input. The direction bank reads back the value last written.
- R4: Writing 1 to a bit of the set bank drives that pin's `pad_out` high from the next cycle on. Bits written 0 leave their pins unchanged. A read of the set bank returns 0.
- R5: Writing 1 to a bit of the clear bank drives that pin's `pad_out` low from the next cycle on. Bits written 0 leave their pins unchanged. A read of the clear bank returns 0.
- R6: A rising edge on the synchronised input (1 now, 0 one cycle earlier) latches the pin's edge-status bit when its rising enable is 1. A falling edge does the same when its falling enable is 1. With both enables set, either edge latches. No edge latches when the enable for its direction is 0.
- R7: The edge-status bank is write-one-to-clear. Bits written 1 clear, bits written 0 are kept, and all ones clears the whole word.
- R8: When an enabled edge arrives in the same cycle as a clear write to its status bit, the bit stays set.
- R9: `irq` is a registered output. It equals the OR of all edge-status bits and reflects a change in the same cycle the status register changes.
- R10: The alternate-function bank has 2W words starting at byte address 7·W·4. Pin p uses bits [2·(p mod 16)+1 : 2·(p mod 16)] of word p/16, and its value appears on `pad_alt[2p+1:2p]`. The value 0 selects plain GPIO.
- R11: Synchronous reset clears direction, output value, both edge enables, edge status, the alternate-function selectors, `irq` and `bus_rdata`.
- R12: Read data appears on `bus_rdata` in the cycle after the request. A read at a misaligned or out-of-range address returns 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_out | output | NUM_PINS | Per-pin output value |
| pad_alt | output | 2·NUM_PINS | Per-pin alternate-function selector |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench builds the controller with 64 pins, which gives two words per bank and four alternate-function words. That is small enough to sweep every pin through set, clear, rising-edge and falling-edge detection one at a time, with the expected words computed by bit arithmetic. With two words, the word index in the address is exercised as well as the bit position. Enabling rising detection on one word and falling detection on the other exposes any cross-over between the two enable banks. The same-cycle acknowledge race and the packed selector layout are each checked at a chosen cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    BK_LEVEL = 3'd0,
    BK_DIR   = 3'd1,
    BK_SET   = 3'd2,
    BK_CLR   = 3'd3,
    BK_RISE  = 3'd4,
    BK_FALL  = 3'd5,
    BK_EDGE  = 3'd6,
    BK_ALT   = 3'd7
  } gpio_bank_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 7,
  parameter int IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output gpio_bank_e        bank_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o
);
  localparam int PLAIN_WORDS = 7 * NUM_WORDS;
  localparam int ALL_WORDS   = 9 * NUM_WORDS;

  int word_n;

  always_comb begin
    word_n  = int'(addr_i[ADDR_W-1:2]);
    bank_o  = BK_LEVEL;
    idx_o   = '0;
    valid_o = 1'b0;
    if (addr_i[1:0] == 2'b00) begin
      if (word_n < PLAIN_WORDS) begin
        bank_o  = gpio_bank_e'(3'(word_n / NUM_WORDS));
        idx_o   = IDX_W'(word_n % NUM_WORDS);
        valid_o = 1'b1;
      end else if (word_n < ALL_WORDS) begin
        bank_o  = BK_ALT;
        idx_o   = IDX_W'(word_n - PLAIN_WORDS);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] sync_o,
  output logic [NUM_PINS-1:0] prev_o
);
  logic [NUM_PINS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

  // the delayed copy always trails the synchronised value by one cycle (R6)
  p_prev_trails_r6: assert property (@(posedge clk) disable iff (rst)
    prev_o == $past(sync_o));
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 64,
  parameter int NUM_WORDS = 2,
  parameter int IDX_W     = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic                rise_we_i,
  input  logic                fall_we_i,
  input  logic [IDX_W-1:0]    word_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] clr_vec_i,
  output logic [NUM_PINS-1:0] rise_en_o,
  output logic [NUM_PINS-1:0] fall_en_o,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] rise_q, fall_q, stat_q, stat_d, evt;
  logic                irq_q;

  assign evt    = (sync_i & ~prev_i & rise_q) | (~sync_i & prev_i & fall_q);
  // a new edge is ORed in after the acknowledge, so it wins the race
  assign stat_d = (stat_q & ~clr_vec_i) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (rise_we_i) rise_q[word_i*WORD_W +: WORD_W] <= wdata_i;
      if (fall_we_i) fall_q[word_i*WORD_W +: WORD_W] <= wdata_i;
      stat_q <= stat_d;
      irq_q  <= |stat_d;
    end
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign status_o  = stat_q;
  assign irq_o     = irq_q;

  // a status bit only appears where an enabled edge was seen (R6)
  p_status_source_r6: assert property (@(posedge clk) disable iff (rst)
    (status_o & ~$past(status_o) & ~$past(evt)) == '0);
  // acknowledged bits drop unless an edge arrives in the same cycle (R7, R8)
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (status_o & $past(clr_vec_i & ~evt)) == '0);
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (status_o & $past(evt)) == $past(evt));
  // enables come out of reset cleared (R11)
  p_reset_enables_r11: assert property (@(posedge clk)
    $past(rst) |-> (rise_en_o == '0 && fall_en_o == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 64,
  parameter int NUM_WORDS = NUM_PINS / WORD_W,
  parameter int ADDR_W    = $clog2(36 * NUM_WORDS),
  parameter int IDX_W     = (2 * NUM_WORDS > 1) ? $clog2(2 * NUM_WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [2*NUM_PINS-1:0] pad_alt,
  output logic                  irq
);
  gpio_bank_e          dec_bank;
  logic [IDX_W-1:0]    dec_idx;
  logic                dec_valid;
  logic                wr_hit, rd_hit;
  logic [NUM_PINS-1:0] lvl_sync, lvl_prev;
  logic [NUM_PINS-1:0] set_vec, clr_vec, ack_vec;
  logic [NUM_PINS-1:0] rise_en, fall_en, edge_stat;
  logic [NUM_PINS-1:0] dir_q, out_q;
  logic [2*NUM_PINS-1:0] alt_q;
  logic [WORD_W-1:0]   rd_word, rdata_q;
  logic                edge_irq;

  gpio_addr_decode #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(bus_addr), .bank_o(dec_bank), .idx_o(dec_idx), .valid_o(dec_valid)
  );

  gpio_pad_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .pad_i(pad_in), .sync_o(lvl_sync), .prev_o(lvl_prev)
  );

  assign wr_hit = bus_sel & bus_wr & dec_valid;
  assign rd_hit = bus_sel & ~bus_wr & dec_valid;

  // spread one written word into full-width write-one masks
  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    ack_vec = '0;
    if (wr_hit && dec_bank == BK_SET) set_vec[dec_idx*WORD_W +: WORD_W] = bus_wdata;
    if (wr_hit && dec_bank == BK_CLR) clr_vec[dec_idx*WORD_W +: WORD_W] = bus_wdata;
    if (wr_hit && dec_bank == BK_EDGE) ack_vec[dec_idx*WORD_W +: WORD_W] = bus_wdata;
  end

  gpio_edge_unit #(
    .NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
  ) u_edge (
    .clk(clk), .rst(rst),
    .sync_i(lvl_sync), .prev_i(lvl_prev),
    .rise_we_i(wr_hit && dec_bank == BK_RISE),
    .fall_we_i(wr_hit && dec_bank == BK_FALL),
    .word_i(dec_idx), .wdata_i(bus_wdata), .clr_vec_i(ack_vec),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .status_o(edge_stat),
    .irq_o(edge_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      alt_q <= '0;
    end else begin
      if (wr_hit && dec_bank == BK_DIR) dir_q[dec_idx*WORD_W +: WORD_W] <= bus_wdata;
      if (wr_hit && dec_bank == BK_ALT) alt_q[dec_idx*WORD_W +: WORD_W] <= bus_wdata;
      out_q <= (out_q | set_vec) & ~clr_vec;
    end
  end

  always_comb begin
    rd_word = '0;
    case (dec_bank)
      BK_LEVEL: rd_word = lvl_sync[dec_idx*WORD_W +: WORD_W];
      BK_DIR:   rd_word = dir_q[dec_idx*WORD_W +: WORD_W];
      BK_RISE:  rd_word = rise_en[dec_idx*WORD_W +: WORD_W];
      BK_FALL:  rd_word = fall_en[dec_idx*WORD_W +: WORD_W];
      BK_EDGE:  rd_word = edge_stat[dec_idx*WORD_W +: WORD_W];
      BK_ALT:   rd_word = alt_q[dec_idx*WORD_W +: WORD_W];
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_hit ? rd_word : '0;
  end

  assign bus_rdata = rdata_q;
  assign pad_oe    = dir_q;
  assign pad_out   = out_q;
  assign pad_alt   = alt_q;
  assign irq       = edge_irq;

  // R4: masked pins go high the next cycle
  p_set_drives_r4: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((pad_out & $past(set_vec)) == $past(set_vec)));
  // R5: masked pins go low the next cycle
  p_clr_drives_r5: assert property (@(posedge clk) disable iff (rst)
    (|clr_vec) |=> ((pad_out & $past(clr_vec)) == '0));
  // R4, R5: pins outside both masks keep their value
  p_unmasked_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((pad_out ^ $past(pad_out)) & ~$past(set_vec | clr_vec)) == '0);
  // R4: the write-only banks read as zero
  p_wo_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && (dec_bank == BK_SET || dec_bank == BK_CLR)) |=> bus_rdata == '0);
  // R9: the interrupt tracks the pending bits
  p_irq_or_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (|edge_stat));
  // R12: nothing valid, nothing returned
  p_bad_addr_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !dec_valid) |=> bus_rdata == '0);
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;
  localparam int N  = 64;
  localparam int NW = N / 32;
  localparam int AW = $clog2(36 * NW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_oe, pad_out;
  logic [2*N-1:0] pad_alt;
  logic          irq;

  int checks = 0, errors = 0;
  logic [N-1:0] exp_out;
  logic [31:0]  rd;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_alt(pad_alt), .irq(irq)
  );

  function automatic logic [AW-1:0] adr(input int bank, input int word);
    return AW'((bank * NW + word) * 4);
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdw(input logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 pad_oe", pad_oe, 0);
    chk("R11 pad_out", pad_out, 0);
    chk("R11 pad_alt", pad_alt, 0);
    chk("R11 irq", irq, 0);
    chk("R11 rdata", bus_rdata, 0);
    for (int w = 0; w < NW; w++) begin
      rdw(adr(4, w), rd); chk("R11 rise enable", rd, 0);
      rdw(adr(5, w), rd); chk("R11 fall enable", rd, 0);
    end

    // R3, R1: direction bank, per-word placement
    wr(adr(1, 0), 32'hA5A5_0F0F);
    wr(adr(1, 1), 32'h1234_5678);
    chk("R3 pad_oe", pad_oe, {32'h1234_5678, 32'hA5A5_0F0F});
    rdw(adr(1, 1), rd); chk("R3 R1 dir readback", rd, 32'h1234_5678);

    // R4, R5: sweep every pin through set, then clear on odd pins
    exp_out = '0;
    for (int p = 0; p < N; p++) begin
      wr(adr(2, p / 32), 32'(1) << (p % 32));
      exp_out[p] = 1'b1;
      chk("R4 set pin", pad_out, exp_out);
    end
    rdw(adr(2, 0), rd); chk("R4 set bank reads 0", rd, 0);
    rdw(adr(3, 1), rd); chk("R5 clear bank reads 0", rd, 0);
    for (int p = 1; p < N; p += 2) begin
      wr(adr(3, p / 32), 32'(1) << (p % 32));
      exp_out[p] = 1'b0;
      chk("R5 clear pin", pad_out, exp_out);
    end
    wr(adr(2, 1), 32'h0);
    chk("R4 zero mask no change", pad_out, exp_out);

    // R2: level follows the synchronised pad regardless of direction
    pad_in = 64'hDEAD_BEEF_0123_4567;
    idle(3);
    rdw(adr(0, 0), rd); chk("R2 level word0", rd, 32'h0123_4567);
    rdw(adr(0, 1), rd); chk("R2 level word1", rd, 32'hDEAD_BEEF);
    wr(adr(0, 0), 32'hFFFF_FFFF);
    rdw(adr(0, 0), rd); chk("R2 level write ignored", rd, 32'h0123_4567);
    chk("R2 level write no pad effect", pad_out, exp_out);

    // R6, R7, R9: rising on word0, falling on word1, every pin
    pad_in = '0;
    idle(4);
    wr(adr(6, 0), 32'hFFFF_FFFF);
    wr(adr(6, 1), 32'hFFFF_FFFF);
    chk("R7 all-ones clears / R9 irq low", irq, 0);
    wr(adr(4, 0), 32'hFFFF_FFFF);
    wr(adr(5, 1), 32'hFFFF_FFFF);
    for (int p = 0; p < N; p++) begin
      logic [31:0] bitw;
      bitw = 32'(1) << (p % 32);
      pad_in[p] = 1'b1;
      idle(4);
      rdw(adr(6, p / 32), rd);
      chk("R6 rise latch", rd, (p < 32) ? bitw : 32'h0);
      chk("R9 irq after rise", irq, (p < 32) ? 1'b1 : 1'b0);
      wr(adr(6, p / 32), bitw);
      pad_in[p] = 1'b0;
      idle(4);
      rdw(adr(6, p / 32), rd);
      chk("R6 fall latch", rd, (p < 32) ? 32'h0 : bitw);
      wr(adr(6, p / 32), bitw);
      chk("R7 ack clears irq", irq, 0);
    end

    // R6: both enables on pin 5 latch either edge
    wr(adr(5, 0), 32'h0000_0020);
    pad_in[5] = 1'b1; idle(4);
    rdw(adr(6, 0), rd); chk("R6 both rise", rd, 32'h20);
    wr(adr(6, 0), 32'h20);
    pad_in[5] = 1'b0; idle(4);
    rdw(adr(6, 0), rd); chk("R6 both fall", rd, 32'h20);
    wr(adr(6, 0), 32'h20);

    // R7: selective acknowledge keeps unwritten bits
    pad_in[1] = 1'b1; pad_in[2] = 1'b1; idle(4);
    wr(adr(6, 0), 32'h0000_0002);
    rdw(adr(6, 0), rd); chk("R7 selective ack", rd, 32'h4);
    chk("R9 irq still pending", irq, 1);
    wr(adr(6, 0), 32'h4);

    // R8: fresh edge on pin 5 in the cycle its ack lands
    pad_in[5] = 1'b1; idle(4);
    pad_in[5] = 1'b0;
    idle(2);
    wr(adr(6, 0), 32'h20);
    rdw(adr(6, 0), rd); chk("R8 edge beats ack", rd, 32'h20);
    wr(adr(6, 0), 32'h20);
    rdw(adr(6, 0), rd); chk("R8 later ack clears", rd, 32'h0);

    // R10: packed selectors, 16 pins per word
    for (int w = 0; w < 2 * NW; w++) wr(AW'((7 * NW + w) * 4), 32'h1111_1111 * (w + 1));
    chk("R10 pad_alt", pad_alt, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
    wr(AW'((7 * NW + 1) * 4), 32'h0000_0300);
    chk("R10 pin20 field", pad_alt[41:40], 2'b11);
    chk("R10 pin21 field", pad_alt[43:42], 2'b00);
    rdw(AW'((7 * NW + 3) * 4), rd); chk("R10 alt readback", rd, 32'h4444_4444);

    // R12: out-of-range and misaligned accesses
    rdw(AW'(9 * NW * 4), rd); chk("R12 out of range read", rd, 0);
    rdw(AW'(4 * NW + 1), rd); chk("R12 misaligned read", rd, 0);
    wr(AW'(NW * 4 + 2), 32'h0);
    chk("R12 misaligned write ignored", pad_oe, {32'h1234_5678, 32'hA5A5_0F0F});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule